// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block collects expiry pulses from five timer channels into one memory-mapped control word and turns them into one level interrupt line per channel. Each channel owns a sticky pending flag, set by a one-cycle expiry pulse from its timer. Each channel also owns an enable bit that software controls.

Software reads and writes the word through a simple single-cycle port. A write loads the enables directly. In the same write, every pending flag written as one is cleared, and flags written as zero are left alone. An interrupt line is high while its channel is both pending and enabled. The line therefore falls only when the flag is cleared or the enable is withdrawn. Enabling a channel that is already pending raises its line at once.

Top module: `timer_irq_ctrl`

## Requirements
- R1: After a synchronous reset every enable bit, every pending flag, every interrupt line and the read data output are 0.
- R2: A write (bus_wr high, bus_addr equal to 0x44) loads enable bit n, held at word bit n for n in 0..4, from bus_wdata bit n. The change is visible from the next clock edge.
- R3: An expiry pulse on expire[n] sets pending flag n, held at word bit 5+n, on that clock edge, whether or not channel n is enabled.
- R4: In a register write, a one at bus_wdata bit 5+n clears pending flag n. A zero there leaves the flag unchanged.
- R5: Each irq[n] is a level output equal to pending flag n AND enable bit n after every clock edge. Enabling a channel whose flag is already set raises its line.
- R6: When an expiry pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Word bits 31..10 always read as 0, and writing ones to them has no effect.
- R8: A write whose address is not 0x44 changes no enable bit and no pending flag.
- R9: A read (bus_rd high, bus_addr equal to 0x44) returns the word as it stood before that edge on bus_rdata, from the next clock edge. In every other cycle bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| expire | input | 5 | One-cycle expiry pulse per channel |
| irq | output | 5 | Level interrupt line per channel |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as an expiry pulse on the same channel. Random traffic rarely lines these up, so a directed step forces the collision. A second directed step checks that a channel left pending while disabled raises its line as soon as its enable is written. After these steps a long random phase runs. In that phase expiry pulses, writes with random enable and clear masks, reads, and accesses to foreign offsets all overlap freely. A bench model predicts every line and every read word.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;

  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } tirq_access_t;

  function automatic tirq_access_t tirq_decode(
    input logic       wr,
    input logic       rd,
    input logic [7:0] addr,
    input logic [7:0] offset
  );
    tirq_access_t a;
    a.wr_hit = wr && (addr == offset);
    a.rd_hit = rd && (addr == offset);
    return a;
  endfunction

endpackage

// File: rtl/timer_irq_flag.sv
module timer_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q,
  output logic flag_d
);
  // set dominates clear when both arrive together
  always_comb flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/timer_irq_status_bank.sv
module timer_irq_status_bank #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] expire,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] stat_q,
  output logic [NUM_CH-1:0] stat_d
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
    timer_irq_flag flag_i (
      .clk    (clk),
      .rst    (rst),
      .set_i  (expire[ch]),
      .clr_i  (clr_mask[ch]),
      .flag_q (stat_q[ch]),
      .flag_d (stat_d[ch])
    );
  end
endmodule

// File: rtl/timer_irq_enable_reg.sv
module timer_irq_enable_reg #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NUM_CH-1:0] load_val,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] en_d
);
  always_comb en_d = load ? load_val : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/timer_irq_readback.sv
module timer_irq_readback #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [NUM_CH-1:0] en_q,
  input  logic [NUM_CH-1:0] stat_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int USED_W = 2 * NUM_CH;

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[NUM_CH-1:0]      = en_q;
    word[USED_W-1:NUM_CH] = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= word;
    else             rdata <= '0;
  end
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl #(
  parameter int          NUM_CH     = 5,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] irq
);
  import timer_irq_pkg::*;

  localparam int STAT_LSB = NUM_CH;
  localparam int STAT_MSB = 2 * NUM_CH - 1;

  tirq_access_t      acc;
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] stat_q, stat_d;
  logic [NUM_CH-1:0] en_q, en_d;

  always_comb begin
    acc      = tirq_decode(bus_wr, bus_rd, 8'(bus_addr), REG_OFFSET);
    clr_mask = acc.wr_hit ? bus_wdata[STAT_MSB:STAT_LSB] : '0;
  end

  timer_irq_status_bank #(.NUM_CH(NUM_CH)) status_i (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .clr_mask (clr_mask),
    .stat_q   (stat_q),
    .stat_d   (stat_d)
  );

  timer_irq_enable_reg #(.NUM_CH(NUM_CH)) enable_i (
    .clk      (clk),
    .rst      (rst),
    .load     (acc.wr_hit),
    .load_val (bus_wdata[NUM_CH-1:0]),
    .en_q     (en_q),
    .en_d     (en_d)
  );

  timer_irq_readback #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) read_i (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (acc.rd_hit),
    .en_q   (en_q),
    .stat_q (stat_q),
    .rdata  (bus_rdata)
  );

  // lines registered from next-state values: no extra cycle of latency
  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= stat_d & en_d;
  end
endmodule

// File: rtl/timer_irq_checker.sv
module timer_irq_checker #(
  parameter int         NUM_CH     = 5,
  parameter int         DATA_W     = 32,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] REG_OFFSET = 8'h44
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] expire,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] stat_q,
  input logic [NUM_CH-1:0] en_q
);
  logic hit;
  always_comb hit = bus_wr && (8'(bus_addr) == REG_OFFSET);

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q & en_q)); // R5

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    hit |=> en_q == $past(bus_wdata[NUM_CH-1:0])); // R2

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(en_q)); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:2*NUM_CH] == '0); // R7

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
      expire[ch] |=> stat_q[ch]); // R3
    AST_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (rst)
      (hit && bus_wdata[NUM_CH+ch] && !expire[ch]) |=> !stat_q[ch]); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!expire[ch] && !(hit && bus_wdata[NUM_CH+ch])) |=> $stable(stat_q[ch])); // R4
  end
endmodule

bind timer_irq_ctrl timer_irq_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
  .irq(irq), .stat_q(stat_q), .en_q(en_q)
);

// File: tb/timer_irq_ctrl_tb_top.sv
module timer_irq_ctrl_tb_top;
  localparam int NUM_CH = 5;
  localparam logic [7:0] OFS = 8'h44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  expire = '0;
  logic [4:0]  irq;

  int n_chk = 0, n_bad = 0;
  logic [4:0]  m_en = '0, m_st = '0;
  logic [31:0] m_rd = '0;

  always #5 clk = ~clk;

  timer_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire(expire), .irq(irq)
  );

  function automatic logic [31:0] word_of(logic [4:0] en, logic [4:0] st);
    return {22'b0, st, en};
  endfunction

  function automatic logic [4:0] next_st(logic [4:0] st, logic [4:0] ex,
                                         logic hit, logic [31:0] wd);
    return ex | (st & ~(hit ? wd[9:5] : 5'b0));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, advance the model, then compare outputs
  task automatic step(logic wr, logic rd, logic [7:0] a, logic [31:0] wd,
                      logic [4:0] ex, string tag_irq, string tag_rd);
    logic wh, rh;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; expire = ex;
    wh = wr && (a == OFS);
    rh = rd && (a == OFS);
    @(posedge clk);
    m_rd = rh ? word_of(m_en, m_st) : 32'h0;
    m_st = next_st(m_st, ex, wh, wd);
    if (wh) m_en = wd[4:0];
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; expire = '0;
    chk(tag_irq, {27'b0, irq}, {27'b0, m_st & m_en});
    chk(tag_rd, bus_rdata, m_rd);
  endtask

  task automatic rd_word(string tag);
    step(1'b0, 1'b1, OFS, 32'h0, 5'b0, "R5 irq", tag);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    chk("R1 irq", {27'b0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd_word("R1 read");
    // R3: disabled channel still latches its pending flag
    step(1'b0, 1'b0, OFS, 0, 5'b00100, "R3 irq", "R9 idle");
    rd_word("R3 pending");
    // R5: enabling a pending channel raises its line
    step(1'b1, 1'b0, OFS, 32'h0000_0004, 5'b0, "R5 enable", "R9 idle");
    rd_word("R4 zero keeps flag");
    // R4: clear with one
    step(1'b1, 1'b0, OFS, 32'h0000_0084, 5'b0, "R4 clear irq", "R9 idle");
    rd_word("R4 cleared");
    // R6: clear and expiry collide on channel 1
    step(1'b1, 1'b0, OFS, 32'h0000_0042, 5'b00010, "R6 irq", "R9 idle");
    rd_word("R6 set wins");
    // R2 + R7: upper bits written with ones
    step(1'b1, 1'b0, OFS, 32'hFFFF_FC1F, 5'b0, "R2 irq", "R9 idle");
    rd_word("R7 upper zero");
    // R8: foreign offset write ignored
    step(1'b1, 1'b0, 8'h40, 32'hFFFF_FFFF, 5'b0, "R8 irq", "R9 idle");
    rd_word("R8 unchanged");
    step(1'b0, 1'b1, 8'h48, 0, 5'b0, "R5 irq", "R9 foreign read");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 8 == 0) ? 8'($urandom) : OFS;
      step(($urandom % 4) == 0, ($urandom % 2) == 0, a, $urandom,
           5'($urandom) & 5'($urandom), "R5 random irq", "R9 random read");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule